// File: doc/BRIEF.md
# Configurable-Ratio Transmit Serializer

This block turns a parallel word into a one-bit serial stream for a high-speed transmit lane. It runs entirely on the fast clock that ticks once per serial bit. The core side presents a word with a one-cycle capture strobe, and the block latches that word into a hold register. A frame counter, sized from the configured ratio, fires a one-cycle load pulse once every J fast cycles. That pulse copies the held word into a shift register, which then emits the word with its most significant active bit first.

The ratio J is an elaboration parameter restricted to 4, 6, 7, 8 or 10. The input port is always 10 bits wide, and only its low J bits are used. Frames follow one another with no idle bit between them. When no new word is strobed in, the held word is sent again in every frame. This keeps the lane busy with a known pattern. Synchronous reset empties every register, so the line stays low until the first load after reset.

Top module: `tx_ser`

## Requirements
- R1: Only bits [J-1:0] of `par_data` are serialized. Bits J and above have no effect on the output.
- R2: The ratio parameter `RATIO` accepts only 4, 6, 7, 8 and 10. Any other value stops elaboration. Each legal value produces frames exactly J bits long.
- R3: On a fast-clock edge where `par_valid` is high, the hold register takes `par_data[J-1:0]`. On any other edge it keeps its value.
- R4: The internal load pulse is high for exactly one fast cycle out of every J. It first occurs on the J-th rising edge after reset is released, and then on every J-th edge after that.
- R5: The load pulse copies the hold register into the shift register. A word captured while a frame is being shifted out does not alter that frame. It goes out in the next frame.
- R6: Within a frame, `ser_out` carries bit J-1 first and bit 0 last. The first bit of the next frame follows immediately, with no gap.
- R7: Synchronous reset clears the frame counter, the hold register and the shift register. `ser_out` is low in the cycle after a reset edge, even mid-frame. If no word is captured after reset, the line stays low.
- R8: If no strobe arrives during a frame, the next frame repeats the last captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Serial-rate clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| par_data | input | 10 | Parallel word from the core; low J bits used |
| par_valid | input | 1 | One-cycle capture strobe for `par_data` |
| ser_out | output | 1 | Serial data, most significant active bit first |

## Verification
The assertions assume two things about the inputs. First, `par_valid` and `par_data` are synchronous to `clk_fast`. Second, reset is held high for at least one rising edge.

They make no assumption about when the strobe arrives relative to the frame. A capture in any cycle must only ever affect the next load.

The stimulus follows a core clock of the fast rate divided by J, phased to the load pulse. Each strobe lasts one cycle and comes just after a load. Inputs change only on the falling edge. While the strobe is low, `par_data` carries changing junk, so that unused and unstrobed data are seen to have no effect.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;

    localparam int MAX_W = 10;

    // Legal serialization ratios.
    function automatic bit ratio_ok(input int r);
        return (r == 4) || (r == 6) || (r == 7) || (r == 8) || (r == 10);
    endfunction

    // Width of a counter that must reach r-1.
    function automatic int cnt_bits(input int r);
        return (r <= 2) ? 1 : $clog2(r);
    endfunction

    // Frame-timing state handed from the counter to the datapath.
    typedef struct packed {
        logic load_en;
        logic first_bit;
    } frame_ev_t;

endpackage

// File: rtl/tx_ser_frame_ctr.sv
module tx_ser_frame_ctr
    import tx_ser_pkg::*;
#(
    parameter int RATIO = 10,
    localparam int CW = cnt_bits(RATIO)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt,
    output frame_ev_t     ev
);

    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        ev.load_en   = (cnt_q == LAST);
        ev.first_bit = (cnt_q == '0);
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/tx_ser_hold.sv
module tx_ser_hold
    import tx_ser_pkg::*;
#(
    parameter int RATIO = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MAX_W-1:0] din,
    input  logic             cap,
    output logic [RATIO-1:0] hold
);

    logic [RATIO-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (cap) begin
            hold_q <= din[RATIO-1:0];
        end
    end

    assign hold = hold_q;

endmodule

// File: rtl/tx_ser_shift.sv
module tx_ser_shift
    import tx_ser_pkg::*;
#(
    parameter int RATIO = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_ev_t        ev,
    input  logic [RATIO-1:0] word,
    output logic [RATIO-1:0] shreg,
    output logic             sdo
);

    logic [RATIO-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (ev.load_en) begin
            sh_q <= word;
        end else begin
            sh_q <= {sh_q[RATIO-2:0], 1'b0};
        end
    end

    assign shreg = sh_q;
    assign sdo   = sh_q[RATIO-1];

endmodule

// File: rtl/tx_ser.sv
module tx_ser
    import tx_ser_pkg::*;
#(
    parameter int RATIO = 10
) (
    input  logic             clk_fast,
    input  logic             rst,
    input  logic [MAX_W-1:0] par_data,
    input  logic             par_valid,
    output logic             ser_out
);

    localparam int CW = cnt_bits(RATIO);

    generate
        if (!ratio_ok(RATIO)) begin : g_bad_ratio
            $error("tx_ser: RATIO must be 4, 6, 7, 8 or 10");
        end
    endgenerate

    logic [CW-1:0]    frm_cnt;
    frame_ev_t        ev;
    logic [RATIO-1:0] hold_q;
    logic [RATIO-1:0] shift_q;
    logic             load_en;

    tx_ser_frame_ctr #(.RATIO(RATIO)) u_ctr (
        .clk (clk_fast),
        .rst (rst),
        .cnt (frm_cnt),
        .ev  (ev)
    );

    tx_ser_hold #(.RATIO(RATIO)) u_hold (
        .clk  (clk_fast),
        .rst  (rst),
        .din  (par_data),
        .cap  (par_valid),
        .hold (hold_q)
    );

    tx_ser_shift #(.RATIO(RATIO)) u_shift (
        .clk   (clk_fast),
        .rst   (rst),
        .ev    (ev),
        .word  (hold_q),
        .shreg (shift_q),
        .sdo   (ser_out)
    );

    assign load_en = ev.load_en;

endmodule

// File: rtl/tx_ser_chk.sv
module tx_ser_chk
    import tx_ser_pkg::*;
#(
    parameter int RATIO = 10,
    localparam int CW = cnt_bits(RATIO)
) (
    input logic             clk,
    input logic             rst,
    input logic [MAX_W-1:0] par_data,
    input logic             par_valid,
    input logic             load_en,
    input logic [CW-1:0]    cnt,
    input logic [RATIO-1:0] hold,
    input logic [RATIO-1:0] shreg,
    input logic             ser_out
);

    int since_q;

    always_ff @(posedge clk) begin
        if (rst || load_en) begin
            since_q <= 0;
        end else begin
            since_q <= since_q + 1;
        end
    end

    AST_LOAD_PERIOD: assert property (@(posedge clk) disable iff (rst)
        load_en |-> (since_q == RATIO - 1)); // R4

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= RATIO - 1); // R4

    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        par_valid |=> (hold == $past(par_data[RATIO-1:0]))); // R3

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        !par_valid |=> $stable(hold)); // R3

    AST_LOAD_XFER: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (shreg == $past(hold))); // R5

    AST_MSB_ORDER: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> (ser_out == $past(shreg[RATIO-2]))); // R6

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !ser_out); // R7

endmodule

bind tx_ser tx_ser_chk #(.RATIO(RATIO)) u_chk (
    .clk       (clk_fast),
    .rst       (rst),
    .par_data  (par_data),
    .par_valid (par_valid),
    .load_en   (load_en),
    .cnt       (frm_cnt),
    .hold      (hold_q),
    .shreg     (shift_q),
    .ser_out   (ser_out)
);

// File: tb/sim_tx_ser.sv
module sim_tx_ser;

    localparam int NR = 5;
    localparam int RAT [NR] = '{10, 4, 6, 7, 8};
    localparam int NV = 6;
    // Upper bits set on purpose in several words (R1).
    localparam logic [9:0] VEC [NV] = '{10'h2B5, 10'h3C1, 10'h0F0, 10'h155, 10'h2AA, 10'h3FF};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] pd [NR];
    logic       pv [NR];
    logic       so [NR];

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tx_ser #(.RATIO(10)) u0 (.clk_fast(clk), .rst(rst), .par_data(pd[0]), .par_valid(pv[0]), .ser_out(so[0]));
    tx_ser #(.RATIO(4))  u1 (.clk_fast(clk), .rst(rst), .par_data(pd[1]), .par_valid(pv[1]), .ser_out(so[1]));
    tx_ser #(.RATIO(6))  u2 (.clk_fast(clk), .rst(rst), .par_data(pd[2]), .par_valid(pv[2]), .ser_out(so[2]));
    tx_ser #(.RATIO(7))  u3 (.clk_fast(clk), .rst(rst), .par_data(pd[3]), .par_valid(pv[3]), .ser_out(so[3]));
    tx_ser #(.RATIO(8))  u4 (.clk_fast(clk), .rst(rst), .par_data(pd[4]), .par_valid(pv[4]), .ser_out(so[4]));

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic run_ratio(input int k);
        int j;
        int mask;
        int nfr;
        int zeros;
        logic [9:0] acc;
        j     = RAT[k];
        mask  = (1 << j) - 1;
        nfr   = NV + 2;
        acc   = '0;
        zeros = 0;

        // R7: reset state.
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(so[k] == 1'b0, "R7", $sformatf("J=%0d output in reset", j), int'(so[k]), 0);

        // Release reset; core word 0 strobed for the first edge.
        rst   = 1'b0;
        pd[k] = VEC[0];
        pv[k] = 1'b1;
        for (int c = 1; c <= j * (nfr + 1) - 1; c++) begin
            @(negedge clk);
            if (c >= j) begin
                acc = {acc[8:0], so[k]};
                if ((c % j) == j - 1) begin
                    int f;
                    int e;
                    f = c / j - 1;
                    e = int'(VEC[(f < NV) ? f : NV - 1]) & mask;
                    // R1 R2 R4 R5 R6 R8: frame f, MSB first, no gap.
                    check((int'(acc) & mask) == e,
                          (f < NV) ? "R6" : "R8",
                          $sformatf("J=%0d frame %0d", j, f), int'(acc) & mask, e);
                end
            end
            if ((c % j) == 0 && (c / j) < NV) begin
                pd[k] = VEC[c / j];
                pv[k] = 1'b1;
            end else begin
                pv[k] = 1'b0;
                pd[k] = 10'(c * 37) ^ 10'h3FF;
            end
        end

        // R7: reset in mid-stream (all-ones word still held) forces the line low.
        rst = 1'b1;
        @(negedge clk);
        check(so[k] == 1'b0, "R7", $sformatf("J=%0d mid-stream reset", j), int'(so[k]), 0);
        @(negedge clk);
        rst = 1'b0;

        // R7: no capture after reset -> cleared hold keeps the line low.
        for (int c = 0; c < 3 * j; c++) begin
            @(negedge clk);
            if (so[k] != 1'b0) zeros++;
        end
        check(zeros == 0, "R7", $sformatf("J=%0d idle high bits after reset", j), zeros, 0);
    endtask

    initial begin
        for (int k = 0; k < NR; k++) begin
            pd[k] = '0;
            pv[k] = 1'b0;
        end
        @(negedge clk);
        for (int k = 0; k < NR; k++) begin
            run_ratio(k);
        end
        finish_run();
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule